// File: doc/BRIEF.md
# Version-Tracked Shared-Line Cache Controller

This block is a small direct-mapped cache controller for one processor in a multiprocessor. Shared data stays cached across task-level boundaries of statically scheduled parallel loops. Staleness is not handled by flushing the cache at each boundary. Instead, the controller keeps a local table with one current version counter per shared variable. Each cached line records the version at which its contents were born and the variable it belongs to. On a shared access, the line's birth version is compared with that variable's current version. An older birth version forces a miss and a refill.

At a boundary, compiler-inserted code issues a command. Its bit mask names every variable that was written during the level just finished, and each selected counter advances by one in a single cycle. A read miss refills the line from the fill data port and stamps it with the current version. A write that hits stores the new data and stamps the line one version ahead, so the writer's own copy stays fresh after the next boundary. Non-shared data ignores versions and relies only on the tag and valid bit.

Version fields are 8 bits. If a boundary would carry any selected counter past its maximum, the controller resets the whole table, invalidates every line and pulses a flush request. This prevents a wrapped comparison from ever reporting a false hit.

Top module: `vcc_ctrl`

## Requirements
- R1: After reset, rsp_valid and flush_req are 0, every version counter is 0, and every line is invalid, so the first read of any address misses.
- R2: Each access cycle (acc_valid=1) produces exactly one response with rsp_valid=1 in the following cycle. rsp_valid is 0 in the cycle after a cycle without an access.
- R3: A read miss loads line acc_addr[2:0] with tag acc_addr[5:3], the mode flag, the variable id, fill_data and birth version equal to the variable's current version. rsp_rdata returns fill_data. A repeated read then hits and returns that same data.
- R4: A write hit replaces the line data with acc_wdata and sets its birth version to the current version plus one, modulo 256. A write response always has rsp_rdata = 0.
- R5: A boundary command increments, in one cycle, every counter whose bnd_mask bit is 1 and leaves the others unchanged. A shared line whose birth version is now below its variable's counter misses.
- R6: A shared access hits only when the line is valid, the tag matches, the line is shared, the line's variable equals acc_var, and its birth version is greater than or equal to that variable's counter. A boundary that does not select the variable leaves such a line hitting.
- R7: A write miss does not allocate; a following read of that address misses.
- R8: A non-shared access (acc_shared=0) hits on valid, tag match and a non-shared line, whatever the version counters hold.
- R9: A boundary that selects a counter holding 255 sets all counters to 0 and invalidates all lines. flush_req is 1 for exactly the following cycle.
- R10: Lines are direct-mapped. A read miss to another tag at the same index replaces the resident line.
- R11: An access in the same cycle as a boundary command is judged against the counters before that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_shared | input | 1 | 1 when the access targets shared data |
| acc_var | input | 2 | Shared variable id of the access |
| acc_addr | input | 6 | Word address: [2:0] index, [5:3] tag |
| acc_wdata | input | 16 | Write data |
| fill_data | input | 16 | Memory data supplied for a refill |
| bnd_valid | input | 1 | Task-level boundary command |
| bnd_mask | input | 4 | One bit per variable written in the finished level |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_hit | output | 1 | 1 when that access hit |
| rsp_rdata | output | 16 | Read data (0 for writes) |
| flush_req | output | 1 | One-cycle pulse after a version wrap |

## Verification
The embedded assertions check these properties on every cycle: the single-cycle response timing, counter hold and single-step increment, counter clearing and line invalidation after a wrap, the birth version written on refill and on write hit, and that a write miss leaves the valid bits unchanged. Only the bench's scenarios can show that hits and misses come out right end to end, because that requires a model of the whole line and counter history. This covers staleness after a boundary, survival of a writer's own line, immunity of non-shared lines, direct-mapped replacement, the same-cycle ordering of an access and a boundary, and the full 256-step climb to a wrap.

// File: rtl/vcc_pkg.sv
package vcc_pkg;

  // Classification of one access, used to steer line updates
  typedef enum logic [1:0] {
    OUTC_IDLE = 2'd0,
    OUTC_HIT  = 2'd1,
    OUTC_FILL = 2'd2,
    OUTC_PASS = 2'd3
  } outcome_e;

  localparam int unsigned DEF_NUM_VARS  = 4;
  localparam int unsigned DEF_NUM_LINES = 8;
  localparam int unsigned DEF_ADDR_W    = 6;
  localparam int unsigned DEF_DATA_W    = 16;
  localparam int unsigned DEF_VER_W     = 8;

endpackage

// File: rtl/vcc_stale_cmp.sv
module vcc_stale_cmp #(
  parameter int unsigned VER_W = 8
) (
  input  logic [VER_W-1:0] bvn,
  input  logic [VER_W-1:0] cvn,
  output logic             fresh
);

  // A line is current when it was born at or after the present version
  assign fresh = (bvn >= cvn);

endmodule

// File: rtl/vcc_version_table.sv
module vcc_version_table #(
  parameter int unsigned NUM_VARS = 4,
  parameter int unsigned VER_W    = 8,
  parameter int unsigned VAR_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bnd_valid,
  input  logic [NUM_VARS-1:0] bnd_mask,
  input  logic [VAR_W-1:0]    rd_var,
  output logic [VER_W-1:0]    rd_cvn,
  output logic                wrap_o
);

  localparam logic [VER_W-1:0] VER_MAX = '1;

  logic [NUM_VARS-1:0][VER_W-1:0] cvn_q;
  logic [NUM_VARS-1:0][VER_W-1:0] cvn_d;
  logic [NUM_VARS-1:0]            at_max;
  logic                           upd_en;

  generate
    for (genvar gi = 0; gi < NUM_VARS; gi++) begin : g_ent
      assign at_max[gi] = bnd_mask[gi] && (cvn_q[gi] == VER_MAX);

      AST_CVN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_valid && !wrap_o && bnd_mask[gi]) |=>
          (cvn_q[gi] == VER_W'($past(cvn_q[gi]) + 1'b1))); // R5
    end
  endgenerate

  assign wrap_o = bnd_valid && (|at_max);
  assign upd_en = bnd_valid;

  always_comb begin
    cvn_d = cvn_q;
    if (wrap_o) begin
      cvn_d = '0;
    end else begin
      for (int i = 0; i < NUM_VARS; i++) begin
        if (bnd_mask[i]) cvn_d[i] = cvn_q[i] + VER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cvn_q <= '0;
    end else if (upd_en) begin
      cvn_q <= cvn_d;
    end
  end

  assign rd_cvn = cvn_q[rd_var];

  AST_CVN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_valid |=> $stable(cvn_q)); // R5

  AST_WRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cvn_q == '0)); // R9

endmodule

// File: rtl/vcc_line_store.sv
module vcc_line_store
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned VER_W     = 8,
  parameter int unsigned VAR_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_shared,
  input  logic [VAR_W-1:0]  acc_var,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [VER_W-1:0]  cvn,
  input  logic              flush,
  output logic              hit,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned IDX_W = $clog2(NUM_LINES);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] valid_d;
  logic [TAG_W-1:0]     tag_q    [NUM_LINES];
  logic                 shared_q [NUM_LINES];
  logic [VAR_W-1:0]     var_q    [NUM_LINES];
  logic [VER_W-1:0]     bvn_q    [NUM_LINES];
  logic [DATA_W-1:0]    data_q   [NUM_LINES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             fresh;
  logic             tag_ok;
  logic             ver_ok;
  logic             ld_fill;
  logic             wr_hit;
  outcome_e         outc;

  assign idx = acc_addr[IDX_W-1:0];
  assign tag = acc_addr[ADDR_W-1:IDX_W];

  vcc_stale_cmp #(.VER_W(VER_W)) u_cmp (
    .bvn   (bvn_q[idx]),
    .cvn   (cvn),
    .fresh (fresh)
  );

  assign tag_ok = valid_q[idx] && (tag_q[idx] == tag) && (shared_q[idx] == acc_shared);
  assign ver_ok = !acc_shared || ((var_q[idx] == acc_var) && fresh);
  assign hit    = tag_ok && ver_ok;
  assign rdata  = hit ? data_q[idx] : fill_data;

  always_comb begin
    if (!acc_valid)     outc = OUTC_IDLE;
    else if (hit)       outc = OUTC_HIT;
    else if (!acc_write) outc = OUTC_FILL;
    else                outc = OUTC_PASS;
  end

  assign ld_fill = (outc == OUTC_FILL) && !flush;
  assign wr_hit  = (outc == OUTC_HIT) && acc_write && !flush;

  always_comb begin
    valid_d = valid_q;
    if (flush) begin
      valid_d = '0;
    end else if (ld_fill) begin
      valid_d[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush || ld_fill) begin
      valid_q <= valid_d;
    end
  end

  // Payload carries no reset: it is only read through a set valid bit
  always_ff @(posedge clk) begin
    if (ld_fill) begin
      tag_q[idx]    <= tag;
      shared_q[idx] <= acc_shared;
      var_q[idx]    <= acc_var;
      bvn_q[idx]    <= cvn;
      data_q[idx]   <= fill_data;
    end else if (wr_hit) begin
      bvn_q[idx]    <= cvn + VER_W'(1);
      data_q[idx]   <= acc_wdata;
    end
  end

  AST_FLUSH_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0)); // R9

  AST_FILL_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fill |=> (valid_q[$past(idx)] && (bvn_q[$past(idx)] == $past(cvn)))); // R3

  AST_WRITE_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (bvn_q[$past(idx)] == VER_W'($past(cvn) + 1'b1))); // R4

  AST_NO_WRITE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !hit && !flush) |=> $stable(valid_q)); // R7

endmodule

// File: rtl/vcc_ctrl.sv
module vcc_ctrl
  import vcc_pkg::*;
#(
  parameter int unsigned NUM_VARS  = DEF_NUM_VARS,
  parameter int unsigned NUM_LINES = DEF_NUM_LINES,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned VER_W     = DEF_VER_W,
  localparam int unsigned VAR_W    = (NUM_VARS > 1) ? $clog2(NUM_VARS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic                acc_shared,
  input  logic [VAR_W-1:0]    acc_var,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic [DATA_W-1:0]   acc_wdata,
  input  logic [DATA_W-1:0]   fill_data,
  input  logic                bnd_valid,
  input  logic [NUM_VARS-1:0] bnd_mask,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                flush_req
);

  logic [1:0]        rst_sync_q;
  logic              rst_ns;
  logic [VER_W-1:0]  cur_cvn;
  logic              wrap;
  logic              ls_hit;
  logic [DATA_W-1:0] ls_rdata;
  logic              rsp_valid_d;
  logic              rsp_hit_d;
  logic [DATA_W-1:0] rsp_rdata_d;
  logic              flush_d;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  vcc_version_table #(
    .NUM_VARS (NUM_VARS),
    .VER_W    (VER_W),
    .VAR_W    (VAR_W)
  ) u_vtab (
    .clk       (clk),
    .rst_n     (rst_ns),
    .bnd_valid (bnd_valid),
    .bnd_mask  (bnd_mask),
    .rd_var    (acc_var),
    .rd_cvn    (cur_cvn),
    .wrap_o    (wrap)
  );

  vcc_line_store #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .VER_W     (VER_W),
    .VAR_W     (VAR_W)
  ) u_lines (
    .clk        (clk),
    .rst_n      (rst_ns),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_shared (acc_shared),
    .acc_var    (acc_var),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .fill_data  (fill_data),
    .cvn        (cur_cvn),
    .flush      (wrap),
    .hit        (ls_hit),
    .rdata      (ls_rdata)
  );

  always_comb begin
    rsp_valid_d = acc_valid;
    rsp_hit_d   = acc_valid && ls_hit;
    rsp_rdata_d = (acc_valid && !acc_write) ? ls_rdata : '0;
    flush_d     = wrap;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
      flush_req <= 1'b0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_hit   <= rsp_hit_d;
      rsp_rdata <= rsp_rdata_d;
      flush_req <= flush_d;
    end
  end

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ns)
    acc_valid |=> rsp_valid); // R2

  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_ns)
    !acc_valid |=> !rsp_valid); // R2

  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_ns)
    flush_req |=> !flush_req); // R9

endmodule

// File: tb/tb_vcc_ctrl.sv
module tb_vcc_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write, acc_shared;
  logic [1:0]  acc_var;
  logic [5:0]  acc_addr;
  logic [15:0] acc_wdata, fill_data;
  logic        bnd_valid;
  logic [3:0]  bnd_mask;
  logic        rsp_valid, rsp_hit, flush_req;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state kept by the bench
  bit         m_v   [8];
  logic [2:0] m_tag [8];
  bit         m_sh  [8];
  logic [1:0] m_var [8];
  logic [7:0] m_bvn [8];
  logic [15:0] m_data [8];
  logic [7:0] m_cvn [4];
  logic [7:0] fill_gen = 8'd0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  vcc_ctrl dut (
    .clk (clk), .rst_n (rst_n),
    .acc_valid (acc_valid), .acc_write (acc_write), .acc_shared (acc_shared),
    .acc_var (acc_var), .acc_addr (acc_addr), .acc_wdata (acc_wdata),
    .fill_data (fill_data), .bnd_valid (bnd_valid), .bnd_mask (bnd_mask),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_rdata (rsp_rdata),
    .flush_req (flush_req)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_boundary(input logic [3:0] mask, output bit wrapped);
    wrapped = 0;
    for (int i = 0; i < 4; i++) if (mask[i] && m_cvn[i] == 8'hFF) wrapped = 1;
    if (wrapped) begin
      for (int i = 0; i < 4; i++) m_cvn[i] = 8'd0;
      for (int i = 0; i < 8; i++) m_v[i] = 0;
    end else begin
      for (int i = 0; i < 4; i++) if (mask[i]) m_cvn[i] = m_cvn[i] + 8'd1;
    end
  endtask

  // xh < 0: take the expected hit from the model; otherwise xh is the intended outcome
  task automatic acc(input bit w, input bit sh, input logic [1:0] v, input logic [5:0] a,
                     input logic [15:0] wd, input int xh, input logic [3:0] bmask, input string req);
    logic [2:0] ix;
    logic [2:0] tg;
    bit mh, eh, wr;
    logic [15:0] fd, xd;
    ix = a[2:0];
    tg = a[5:3];
    fill_gen = fill_gen + 8'd1;
    fd = {fill_gen, 2'b00, a};
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_shared = sh; acc_var = v; acc_addr = a;
    acc_wdata = wd; fill_data = fd;
    bnd_valid = (bmask != 4'd0); bnd_mask = bmask;
    mh = m_v[ix] && (m_tag[ix] == tg) && (m_sh[ix] == sh) &&
         (!sh || ((m_var[ix] == v) && (m_bvn[ix] >= m_cvn[v])));
    eh = (xh < 0) ? mh : (xh != 0);
    xd = w ? 16'd0 : (eh ? m_data[ix] : fd);
    if (!w && !mh) begin
      m_v[ix] = 1; m_tag[ix] = tg; m_sh[ix] = sh; m_var[ix] = v;
      m_bvn[ix] = m_cvn[v]; m_data[ix] = fd;
    end else if (w && mh) begin
      m_bvn[ix] = m_cvn[v] + 8'd1; m_data[ix] = wd;
    end
    if (bmask != 4'd0) model_boundary(bmask, wr);
    @(negedge clk);
    acc_valid = 0; bnd_valid = 0; bnd_mask = 4'd0;
    check(rsp_valid == 1'b1, "R2", 32'(rsp_valid), 32'd1);
    check(rsp_hit == eh, req, 32'(rsp_hit), 32'(eh));
    check(rsp_rdata == xd, req, 32'(rsp_rdata), 32'(xd));
  endtask

  task automatic bnd(input logic [3:0] mask, input string req);
    bit wr;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2", 32'(rsp_valid), 32'd0);
    bnd_valid = 1; bnd_mask = mask;
    model_boundary(mask, wr);
    @(negedge clk);
    bnd_valid = 0; bnd_mask = 4'd0;
    check(flush_req == wr, req, 32'(flush_req), 32'(wr));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; acc_valid = 0; acc_write = 0; acc_shared = 0; acc_var = 0;
    acc_addr = 0; acc_wdata = 0; fill_data = 0; bnd_valid = 0; bnd_mask = 0;
    for (int i = 0; i < 8; i++) m_v[i] = 0;
    for (int i = 0; i < 4; i++) m_cvn[i] = 8'd0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 32'd0);
    check(flush_req == 1'b0, "R1", 32'(flush_req), 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 32'd0);

    // R1: every line misses after reset
    for (int i = 0; i < 8; i++) acc(0, 1, 2'd0, {3'd7, 3'(i)}, 16'd0, 0, 4'd0, "R1");

    // R3, R5, R6, R4
    acc(0, 1, 2'd1, 6'd5, 16'd0, 0, 4'd0, "R3");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 1, 4'd0, "R3");
    bnd(4'b0010, "R5");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 0, 4'd0, "R5");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 1, 4'd0, "R6");
    acc(1, 1, 2'd1, 6'd5, 16'hBEEF, 1, 4'd0, "R4");
    bnd(4'b0010, "R5");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 1, 4'd0, "R4");
    bnd(4'b0100, "R6");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 1, 4'd0, "R6");
    // R6: variable id mismatch misses
    acc(0, 1, 2'd2, 6'd5, 16'd0, 0, 4'd0, "R6");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 0, 4'd0, "R6");

    // R7: write miss does not allocate
    acc(1, 1, 2'd0, 6'd9, 16'h1234, 0, 4'd0, "R7");
    acc(0, 1, 2'd0, 6'd9, 16'd0, 0, 4'd0, "R7");

    // R8: non-shared lines ignore boundaries
    acc(0, 0, 2'd0, 6'd2, 16'd0, 0, 4'd0, "R8");
    bnd(4'b1111, "R5");
    acc(0, 0, 2'd0, 6'd2, 16'd0, 1, 4'd0, "R8");
    acc(0, 1, 2'd0, 6'd2, 16'd0, 0, 4'd0, "R8");

    // R10: same index, different tag replaces
    acc(0, 1, 2'd1, 6'd13, 16'd0, 0, 4'd0, "R10");
    acc(0, 1, 2'd1, 6'd5, 16'd0, 0, 4'd0, "R10");
    acc(0, 1, 2'd1, 6'd13, 16'd0, 0, 4'd0, "R10");

    // R11: access alongside a boundary sees the old counter
    acc(0, 1, 2'd1, 6'd13, 16'd0, 1, 4'b0010, "R11");
    acc(0, 1, 2'd1, 6'd13, 16'd0, 0, 4'd0, "R11");

    // Sweep against the model (R3 R4 R6 behaviours mixed)
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      logic [1:0] v;
      bit sh;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a  = {2'b00, lfsr[9:6]};
      v  = {a[3], a[0]};
      sh = !(a[3:0] == 4'd3 || a[3:0] == 4'd12);
      if (lfsr[2:0] == 3'd0) bnd(lfsr[7:4], "R5");
      else acc(lfsr[3] & lfsr[11], sh, v, a, lfsr ^ 16'h5555, -1, 4'd0, "R6");
    end

    // R9: climb variable 0 to its maximum, then wrap
    acc(0, 0, 2'd0, 6'd3, 16'd0, -1, 4'd0, "R8");
    acc(0, 1, 2'd3, 6'd4, 16'd0, -1, 4'd0, "R3");
    while (m_cvn[0] != 8'hFF) bnd(4'b0001, "R5");
    acc(0, 0, 2'd0, 6'd3, 16'd0, 1, 4'd0, "R8");
    bnd(4'b0001, "R9");
    @(negedge clk);
    check(flush_req == 1'b0, "R9", 32'(flush_req), 32'd0);
    acc(0, 0, 2'd0, 6'd3, 16'd0, 0, 4'd0, "R9");
    acc(0, 1, 2'd3, 6'd4, 16'd0, 0, 4'd0, "R9");
    bnd(4'b0001, "R9");
    acc(0, 1, 2'd0, 6'd3, 16'd0, 0, 4'd0, "R9");
    acc(0, 1, 2'd0, 6'd3, 16'd0, 1, 4'd0, "R9");

    done = 1;
    finish_run();
  end

endmodule